// File: doc/BRIEF.md
# Dual-Mode Receive Message Framer

This block collects a byte stream from a radio receiver and writes each message into an external synchronous static RAM. A sleeping host processor is woken once, when a whole message is ready. It is not involved while the bytes arrive. The payload goes only to the RAM. The block itself keeps only control state: a byte count, the expected length, an idle counter and the state flags.

A configuration input selects one of two framings. In length-prefixed framing, the first byte of a message gives the number of payload bytes that follow. In delimiter framing, the block ignores traffic until a start character arrives. It then stores bytes until an end character arrives, and neither delimiter is written.

After a message completes, the wake output stays high until the host acknowledges it. The host reads the stored byte count from a dedicated output. A receive idle time-out abandons a message whose bytes stop arriving. A message that fills the RAM is closed with an overflow indication.

Top module: `rx_msg_framer`

## Requirements
- R1: After reset, wake, sramWe, overflowFlag and timeoutFlag are low and msgLength is 0.
- R2: With modeDelim low, the first accepted byte N is the payload length. The next N bytes are written in arrival order to addresses 0 to N-1, each as one write pulse in the cycle after the byte is accepted. wake rises in the same cycle as the last write, and msgLength then reads N.
- R3: With modeDelim low, a length byte of 0 raises wake in the next cycle with msgLength 0 and no write.
- R4: With modeDelim high and no message in progress, every byte other than the start character 0x02 is discarded, with no write and no wake.
- R5: With modeDelim high, each byte after the start character is written from address 0 upward until the end character 0x03 arrives. Neither delimiter is written. wake rises in the cycle after the end character, and msgLength reads the payload count.
- R6: modeDelim is sampled only with the first byte of a message. Changing it during the message has no effect on how that message is framed.
- R7: When the stored count reaches the RAM depth (2^ADDR_W) before the message completes, the message ends with wake and overflowFlag high and msgLength equal to the depth. A length byte exactly equal to the depth completes without overflow.
- R8: wake stays high until a cycle with hostAck high. While wake is high, received bytes cause no write and leave msgLength unchanged. The acknowledge clears overflowFlag and readies the block for a new message.
- R9: During a message, timeoutLimit consecutive cycles without rxValid return the block to idle with timeoutFlag set and wake low. A shorter gap does not do this. timeoutFlag clears when the next message starts, and a timeoutLimit of 0 disables the time-out.
- R10: hostAck while wake is low has no effect. A message in progress continues and completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeDelim | input | 1 | Framing select: 0 length-prefixed, 1 delimiter |
| rxValid | input | 1 | Receive byte strobe |
| rxData | input | 8 | Received byte |
| hostAck | input | 1 | Host acknowledge of a completed message |
| timeoutLimit | input | TO_W | Idle cycles allowed inside a message, 0 disables |
| sramAddr | output | ADDR_W | SRAM write address |
| sramData | output | 8 | SRAM write data |
| sramWe | output | 1 | SRAM write enable |
| wake | output | 1 | Host wake, message complete |
| msgLength | output | ADDR_W+1 | Number of payload bytes stored |
| overflowFlag | output | 1 | Message was cut at RAM depth |
| timeoutFlag | output | 1 | Last message was abandoned on idle time-out |

## Verification
The bench goes after the corners of framing, acknowledge and time-out, and each has a known failure signature:
- Length 0: a design that mishandles it would hang waiting for payload.
- Length exactly the RAM depth: an off-by-one design would raise a false overflow.
- Delimiter framing: a delimiter-handling error would store the start or end character.
- Mode switched mid-message: a design that does not latch the mode would end a length-framed message early on a 0x03 byte.
- Bytes sent while wake is high: if these are not dropped, the stored message is overwritten.
- Idle gaps of exactly one less than, and equal to, the time-out limit: these expose an off-by-one in the idle counter.
- Random messages in both modes with random gaps: these are compared against counts and overflow expectations computed by bench functions.

// File: rtl/framer_pkg.sv
package framer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_WAKE    = 2'd2
  } frameState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLen;
    logic clrCnt;
    logic storeByte;
    logic clrIdle;
    logic incIdle;
  } dpStrobe_t;

  // compare results from datapath to control
  typedef struct packed {
    logic lenHit;
    logic depthHit;
    logic idleExpired;
  } dpStatus_t;

endpackage

// File: rtl/framer_dpath.sv
module framer_dpath
  import framer_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int TO_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strb,
  input  logic [7:0]          rxData,
  input  logic [TO_W-1:0]     timeoutLimit,
  output dpStatus_t           status,
  output logic [ADDR_W-1:0]   sramAddr,
  output logic [7:0]          sramData,
  output logic                sramWe,
  output logic [ADDR_W:0]     msgLength
);

  localparam int CW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [CW-1:0]   byteCnt;
  logic [CW-1:0]   cntNext;
  logic [7:0]      lenReg;
  logic [TO_W-1:0] idleCnt;

  assign cntNext = byteCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt  <= '0;
      lenReg   <= '0;
      idleCnt  <= '0;
      sramWe   <= 1'b0;
      sramAddr <= '0;
      sramData <= '0;
    end else begin
      if (strb.clrCnt)         byteCnt <= '0;
      else if (strb.storeByte) byteCnt <= cntNext;

      if (strb.loadLen) lenReg <= rxData;

      if (strb.clrIdle)      idleCnt <= '0;
      else if (strb.incIdle) idleCnt <= idleCnt + 1'b1;

      sramWe <= strb.storeByte;
      if (strb.storeByte) begin
        sramAddr <= byteCnt[ADDR_W-1:0];
        sramData <= rxData;
      end
    end
  end

  always_comb begin
    status.lenHit      = (16'(cntNext) == 16'(lenReg));
    status.depthHit    = (cntNext == CW'(DEPTH));
    status.idleExpired = (timeoutLimit != '0) && (idleCnt == timeoutLimit - 1'b1);
  end

  assign msgLength = byteCnt;

endmodule

// File: rtl/framer_ctrl.sv
module framer_ctrl
  import framer_pkg::*;
#(
  parameter logic [7:0] START_BYTE = 8'h02,
  parameter logic [7:0] END_BYTE   = 8'h03
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeDelim,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  input  logic       hostAck,
  input  dpStatus_t  status,
  output dpStrobe_t  strb,
  output logic       wake,
  output logic       overflowFlag,
  output logic       timeoutFlag
);

  frameState_t state, nextState;
  logic modeReg;
  logic latchMode, setOvf, setTo, clrTo;

  always_comb begin
    strb      = '0;
    nextState = state;
    latchMode = 1'b0;
    setOvf    = 1'b0;
    setTo     = 1'b0;
    clrTo     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        strb.clrCnt  = 1'b1;
        strb.clrIdle = 1'b1;
        if (rxValid) begin
          if (!modeDelim) begin
            strb.loadLen = 1'b1;
            latchMode    = 1'b1;
            clrTo        = 1'b1;
            nextState    = (rxData == 8'd0) ? ST_WAKE : ST_COLLECT;
          end else if (rxData == START_BYTE) begin
            latchMode = 1'b1;
            clrTo     = 1'b1;
            nextState = ST_COLLECT;
          end
        end
      end
      ST_COLLECT: begin
        if (rxValid) begin
          strb.clrIdle = 1'b1;
          if (modeReg && rxData == END_BYTE) begin
            nextState = ST_WAKE;
          end else begin
            strb.storeByte = 1'b1;
            if (!modeReg && status.lenHit) begin
              nextState = ST_WAKE;
            end else if (status.depthHit) begin
              nextState = ST_WAKE;
              setOvf    = 1'b1;
            end
          end
        end else if (status.idleExpired) begin
          nextState = ST_IDLE;
          setTo     = 1'b1;
        end else begin
          strb.incIdle = 1'b1;
        end
      end
      ST_WAKE: begin
        if (hostAck) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      modeReg      <= 1'b0;
      overflowFlag <= 1'b0;
      timeoutFlag  <= 1'b0;
    end else begin
      state <= nextState;
      if (latchMode) modeReg <= modeDelim;
      if (state == ST_WAKE && hostAck) overflowFlag <= 1'b0;
      else if (setOvf)                 overflowFlag <= 1'b1;
      if (setTo)      timeoutFlag <= 1'b1;
      else if (clrTo) timeoutFlag <= 1'b0;
    end
  end

  assign wake = (state == ST_WAKE);

endmodule

// File: rtl/rx_msg_framer.sv
module rx_msg_framer
  import framer_pkg::*;
#(
  parameter int         ADDR_W     = 6,
  parameter int         TO_W       = 16,
  parameter logic [7:0] START_BYTE = 8'h02,
  parameter logic [7:0] END_BYTE   = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeDelim,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              hostAck,
  input  logic [TO_W-1:0]   timeoutLimit,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [7:0]        sramData,
  output logic              sramWe,
  output logic              wake,
  output logic [ADDR_W:0]   msgLength,
  output logic              overflowFlag,
  output logic              timeoutFlag
);

  dpStrobe_t strb;
  dpStatus_t status;

  framer_ctrl #(
    .START_BYTE(START_BYTE),
    .END_BYTE  (END_BYTE)
  ) ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .modeDelim   (modeDelim),
    .rxValid     (rxValid),
    .rxData      (rxData),
    .hostAck     (hostAck),
    .status      (status),
    .strb        (strb),
    .wake        (wake),
    .overflowFlag(overflowFlag),
    .timeoutFlag (timeoutFlag)
  );

  framer_dpath #(
    .ADDR_W(ADDR_W),
    .TO_W  (TO_W)
  ) dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .rxData      (rxData),
    .timeoutLimit(timeoutLimit),
    .status      (status),
    .sramAddr    (sramAddr),
    .sramData    (sramData),
    .sramWe      (sramWe),
    .msgLength   (msgLength)
  );

endmodule

// File: rtl/rx_msg_framer_chk.sv
module rx_msg_framer_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostAck,
  input logic [ADDR_W-1:0] sramAddr,
  input logic              sramWe,
  input logic              wake,
  input logic [ADDR_W:0]   msgLength,
  input logic              overflowFlag,
  input logic              timeoutFlag
);

  localparam int DEPTH = 1 << ADDR_W;

  AST_WRITE_TRACKS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    sramWe |-> (msgLength == ({1'b0, sramAddr} + 1'b1)));  // R2

  AST_WAKE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (wake && !hostAck) |=> wake);  // R8

  AST_DROP_IN_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (wake && $past(wake)) |-> !sramWe);  // R8

  AST_WAKE_LEN_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (wake && $past(wake)) |-> $stable(msgLength));  // R8

  AST_TIMEOUT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> (!wake && !sramWe));  // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |-> wake);  // R7

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    msgLength <= (ADDR_W+1)'(DEPTH));  // R7

endmodule

bind rx_msg_framer rx_msg_framer_chk #(.ADDR_W(ADDR_W)) chk (
  .clk         (clk),
  .rstN        (rstN),
  .hostAck     (hostAck),
  .sramAddr    (sramAddr),
  .sramWe      (sramWe),
  .wake        (wake),
  .msgLength   (msgLength),
  .overflowFlag(overflowFlag),
  .timeoutFlag (timeoutFlag)
);

// File: tb/rx_msg_framer_test.sv
`timescale 1ns/1ps
module rx_msg_framer_test;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN;
  logic          modeDelim;
  logic          rxValid;
  logic [7:0]    rxData;
  logic          hostAck;
  logic [15:0]   timeoutLimit;
  logic [AW-1:0] sramAddr;
  logic [7:0]    sramData;
  logic          sramWe;
  logic          wake;
  logic [AW:0]   msgLength;
  logic          overflowFlag;
  logic          timeoutFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] capMem [0:DEPTH-1];
  logic [7:0] msgBuf [0:255];
  int capCount = 0;
  int addrErr  = 0;

  always #10 clk = ~clk;  // 50 MHz

  rx_msg_framer #(.ADDR_W(AW), .TO_W(16)) uut (
    .clk(clk), .rstN(rstN), .modeDelim(modeDelim), .rxValid(rxValid),
    .rxData(rxData), .hostAck(hostAck), .timeoutLimit(timeoutLimit),
    .sramAddr(sramAddr), .sramData(sramData), .sramWe(sramWe), .wake(wake),
    .msgLength(msgLength), .overflowFlag(overflowFlag), .timeoutFlag(timeoutFlag)
  );

  // write capture, a quarter period after the edge
  always @(posedge clk) begin
    #5;
    if (rstN && sramWe) begin
      if (int'(sramAddr) != capCount) addrErr++;
      capMem[sramAddr] = sramData;
      capCount++;
    end
  end

  function automatic int expStored(int n);
    return (n > DEPTH) ? DEPTH : n;
  endfunction

  function automatic int expOvf(bit delim, int n);
    if (delim) return (n >= DEPTH) ? 1 : 0;
    return (n > DEPTH) ? 1 : 0;
  endfunction

  function automatic logic [7:0] pickByte(logic [7:0] excl);
    logic [7:0] r;
    r = 8'($urandom_range(255));
    while (r == excl) r = 8'($urandom_range(255));
    return r;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // all stimulus tasks start and end at a falling edge
  task automatic putByte(logic [7:0] b);
    rxValid = 1'b1;
    rxData  = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic ack();
    hostAck = 1'b1;
    @(negedge clk);
    hostAck = 1'b0;
  endtask

  task automatic clearCap();
    capCount = 0;
    addrErr  = 0;
  endtask

  task automatic verifyMsg(string req, bit delim, int n);
    int expN;
    int mism;
    expN = expStored(n);
    mism = 0;
    for (int i = 0; i < expN; i++) if (capMem[i] !== msgBuf[i]) mism++;
    chk(req, "wake", int'(wake), 1);
    chk(req, "msgLength", int'(msgLength), expN);
    chk(req, "overflowFlag", int'(overflowFlag), expOvf(delim, n));
    chk(req, "write count", capCount, expN);
    chk(req, "address order errors", addrErr, 0);
    chk(req, "payload mismatches", mism, 0);
  endtask

  task automatic runLength(int n, int gapMax);
    clearCap();
    modeDelim = 1'b0;
    putByte(8'(n));
    for (int i = 0; i < n; i++) begin
      msgBuf[i] = 8'($urandom_range(255));
      putByte(msgBuf[i]);
      if (gapMax > 0) idle($urandom_range(gapMax));
    end
  endtask

  task automatic runDelim(int n, int junk, int gapMax);
    clearCap();
    modeDelim = 1'b1;
    for (int i = 0; i < junk; i++) putByte(pickByte(8'h02));
    putByte(8'h02);
    for (int i = 0; i < n; i++) begin
      msgBuf[i] = pickByte(8'h03);
      putByte(msgBuf[i]);
      if (gapMax > 0) idle($urandom_range(gapMax));
    end
    putByte(8'h03);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    rstN = 1'b0; modeDelim = 1'b0; rxValid = 1'b0; rxData = '0;
    hostAck = 1'b0; timeoutLimit = 16'd1000;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "wake", int'(wake), 0);
    chk("R1", "sramWe", int'(sramWe), 0);
    chk("R1", "msgLength", int'(msgLength), 0);
    chk("R1", "flags", int'({overflowFlag, timeoutFlag}), 0);

    // R2 length-prefixed, back to back
    clearCap();
    putByte(8'd3);
    msgBuf[0] = 8'hA1; msgBuf[1] = 8'hB2; msgBuf[2] = 8'hC3;
    putByte(8'hA1); putByte(8'hB2);
    chk("R2", "wake before last byte", int'(wake), 0);
    putByte(8'hC3);
    verifyMsg("R2", 1'b0, 3);

    // R8 bytes while wake are dropped, wake held
    putByte(8'h55); putByte(8'h66);
    idle(3);
    chk("R8", "wake held", int'(wake), 1);
    chk("R8", "writes while wake", capCount, 3);
    chk("R8", "msgLength while wake", int'(msgLength), 3);
    ack();
    chk("R8", "wake after ack", int'(wake), 0);

    // R3 zero length
    clearCap();
    putByte(8'd0);
    chk("R3", "wake", int'(wake), 1);
    chk("R3", "msgLength", int'(msgLength), 0);
    chk("R3", "writes", capCount, 0);
    ack();

    // R10 ack while idle and mid-message
    ack();
    chk("R10", "wake after idle ack", int'(wake), 0);
    clearCap();
    putByte(8'd2);
    msgBuf[0] = 8'h11; msgBuf[1] = 8'h22;
    putByte(8'h11);
    ack();
    putByte(8'h22);
    verifyMsg("R10", 1'b0, 2);
    ack();

    // R4 junk before start in delimiter mode
    clearCap();
    modeDelim = 1'b1;
    putByte(8'h03); putByte(8'h41); putByte(8'hFF);
    idle(2);
    chk("R4", "wake", int'(wake), 0);
    chk("R4", "writes", capCount, 0);

    // R5 delimiter message including a stray start byte in payload
    putByte(8'h02);
    msgBuf[0] = 8'h10; msgBuf[1] = 8'h02; msgBuf[2] = 8'h20;
    putByte(8'h10); putByte(8'h02); putByte(8'h20);
    chk("R5", "wake before end", int'(wake), 0);
    putByte(8'h03);
    verifyMsg("R5", 1'b1, 3);
    ack();

    // R6 mode changed inside a length-prefixed message
    clearCap();
    modeDelim = 1'b0;
    putByte(8'd3);
    modeDelim = 1'b1;
    msgBuf[0] = 8'h03; msgBuf[1] = 8'h05; msgBuf[2] = 8'h03;
    putByte(8'h03);
    chk("R6", "no early wake", int'(wake), 0);
    putByte(8'h05); putByte(8'h03);
    verifyMsg("R6", 1'b0, 3);
    ack();

    // R7 overflow and exact-depth cases
    runLength(100, 0);
    verifyMsg("R7", 1'b0, 100);
    ack();
    chk("R7", "overflow cleared by ack", int'(overflowFlag), 0);
    runLength(DEPTH, 0);
    verifyMsg("R7", 1'b0, DEPTH);
    ack();
    runDelim(DEPTH, 2, 0);
    verifyMsg("R7", 1'b1, DEPTH);
    ack();
    runDelim(DEPTH - 1, 0, 0);
    verifyMsg("R7", 1'b1, DEPTH - 1);
    ack();

    // R9 time-out
    timeoutLimit = 16'd5;
    modeDelim = 1'b0;
    clearCap();
    putByte(8'd4); putByte(8'h01); putByte(8'h02);
    idle(4);
    putByte(8'h03);
    chk("R9", "short gap no time-out", int'(timeoutFlag), 0);
    idle(5);
    chk("R9", "timeoutFlag", int'(timeoutFlag), 1);
    chk("R9", "wake after time-out", int'(wake), 0);
    clearCap();
    putByte(8'd1);
    chk("R9", "timeoutFlag cleared on new message", int'(timeoutFlag), 0);
    msgBuf[0] = 8'h77;
    putByte(8'h77);
    verifyMsg("R9", 1'b0, 1);
    ack();
    timeoutLimit = 16'd0;
    clearCap();
    putByte(8'd2);
    msgBuf[0] = 8'h31; msgBuf[1] = 8'h32;
    putByte(8'h31);
    idle(300);
    chk("R9", "limit 0 disables time-out", int'(timeoutFlag), 0);
    putByte(8'h32);
    verifyMsg("R9", 1'b0, 2);
    ack();

    // random messages in both modes, gaps below the limit
    timeoutLimit = 16'd8;
    for (int m = 0; m < 40; m++) begin
      int n;
      n = $urandom_range(70);
      if ($urandom_range(1) == 0) begin
        runLength(n, 6);
        verifyMsg("R2", 1'b0, n);
      end else begin
        runDelim(n, $urandom_range(3), 6);
        verifyMsg("R5", 1'b1, n);
      end
      idle($urandom_range(3));
      ack();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule